// File: doc/BRIEF.md
# Flash Protected Range Checker

This block sits beside a flash controller's sequencer and decides, before any flash cycle starts, whether a requested access is allowed. It holds a small bank of protected-range words. Each word describes a span of flash in 4 KiB units and carries two separate enables: one that blocks reads and one that blocks writes and erases.

The sequencer presents an access as a start byte address, a byte count minus one and a direction bit. The checker compares the whole span of that access against every enabled range. One clock later it returns a valid strobe and an error flag. Range words are written through a simple indexed write port. A lock input freezes them, and an indexed read port returns their contents.

Top module: `flash_range_guard`

## Requirements
- R1: After reset every range word reads as zero, and both `err_valid_o` and `err_o` are low.
- R2: A range word has its base (4 KiB units) in bits 13:0, a read-protect enable in bit 15, an inclusive limit (4 KiB units) in bits 29:16 and a write-protect enable in bit 31. Bits 14 and 30 are stored but have no effect on the check.
- R3: A range covers the bytes from base*4096 through limit*4096+4095, both ends included.
- R4: A range whose read-protect and write-protect enables are both clear never causes an error.
- R5: A read (`chk_write_i`=0) is flagged when it overlaps a range with read-protect set, and is not flagged by a range that has only write-protect set.
- R6: A write or erase (`chk_write_i`=1) is flagged when it overlaps a range with write-protect set, and is not flagged by a range that has only read-protect set.
- R7: The check uses the whole access, from `chk_addr_i` to `chk_addr_i`+`chk_len_i` inclusive. An access that starts outside a range but reaches into it is flagged; this includes 4 KiB and 64 KiB erase spans.
- R8: While `lock_i` is high, writes on the configuration port leave every range word unchanged.
- R9: `err_valid_o` is high exactly in the cycle after a cycle with `chk_req_i` high, and `err_o` is low whenever `err_valid_o` is low.
- R10: A range whose base is greater than its limit matches no address, even when its enables are set.
- R11: `cfg_rdata_o` returns the word stored at index `cfg_idx_i`. An index at or above NUM_RANGES reads as zero, and a write to such an index changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Freezes the range words while high |
| cfg_we_i | input | 1 | Range word write strobe |
| cfg_idx_i | input | IDX_W | Range word index, used for both write and read |
| cfg_wdata_i | input | 32 | Range word write data |
| cfg_rdata_o | output | 32 | Range word at `cfg_idx_i` |
| chk_req_i | input | 1 | Check request |
| chk_addr_i | input | ADDR_W | First byte address of the access |
| chk_len_i | input | LEN_W | Byte count of the access minus one |
| chk_write_i | input | 1 | 1 = write or erase, 0 = read |
| err_valid_o | output | 1 | Result valid, one cycle after the request |
| err_o | output | 1 | Access violates an enabled range |

## Verification
The hardest cases to reach are accesses whose ends fall exactly on a range boundary: the last byte of the access one byte below the base, or the first byte exactly on the inclusive limit byte. Accesses that start outside a range and reach into it only through their length are similarly hard. The stimulus places ranges at known 4 KiB pages, then aims single-byte probes at each edge byte and erase-sized spans that end just short of a range or just inside it. Inverted and fully disabled ranges are placed in the path of wide spans to show that they stay silent. A behavioural model in the bench predicts the result on every clock.

// File: rtl/frg_pkg.sv
package frg_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned PAGE_SH  = 12;
   localparam int unsigned FIELD_W  = 14;
   localparam int unsigned BASE_LSB = 0;
   localparam int unsigned RP_BIT   = 15;
   localparam int unsigned LIM_LSB  = 16;
   localparam int unsigned WP_BIT   = 31;

   typedef struct packed {
      logic [FIELD_W-1:0] base;
      logic [FIELD_W-1:0] limit;
      logic               rd_prot;
      logic               wr_prot;
   } range_t;

   function automatic range_t unpack_range(input logic [WORD_W-1:0] w);
      range_t r;
      r.base    = w[BASE_LSB +: FIELD_W];
      r.limit   = w[LIM_LSB  +: FIELD_W];
      r.rd_prot = w[RP_BIT];
      r.wr_prot = w[WP_BIT];
      return r;
   endfunction
endpackage

// File: rtl/frg_regfile.sv
module frg_regfile #(
   parameter int unsigned NUM   = 6,
   parameter int unsigned IDX_W = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              lock_i,
   input  logic                              we_i,
   input  logic [IDX_W-1:0]                  idx_i,
   input  logic [frg_pkg::WORD_W-1:0]        wdata_i,
   output logic [NUM-1:0][frg_pkg::WORD_W-1:0] regs_o
);
   import frg_pkg::*;

   logic wr_ok;
   assign wr_ok = we_i & ~lock_i;

   for (genvar g = 0; g < NUM; g++) begin : g_ent
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_ok && idx_i == IDX_W'(g)) begin
            word_q <= wdata_i;
         end
      end
      assign regs_o[g] = word_q;
   end
endmodule

// File: rtl/frg_match.sv
module frg_match #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [frg_pkg::WORD_W-1:0] word_i,
   input  logic [ADDR_W:0]            first_i,
   input  logic [ADDR_W:0]            last_i,
   input  logic                       is_write_i,
   output logic                       hit_o
);
   import frg_pkg::*;

   localparam int unsigned SPAN_W = ADDR_W + 1;

   range_t            rng;
   logic [SPAN_W-1:0] lo_byte;
   logic [SPAN_W-1:0] hi_byte;
   logic              armed;
   logic              ordered;
   logic              unused_bits;

   assign rng         = unpack_range(word_i);
   assign unused_bits = ^{word_i[14], word_i[30]};
   assign lo_byte     = SPAN_W'(rng.base)  << PAGE_SH;
   assign hi_byte     = (SPAN_W'(rng.limit) << PAGE_SH) | SPAN_W'((1 << PAGE_SH) - 1);
   assign armed       = is_write_i ? rng.wr_prot : rng.rd_prot;
   assign ordered     = rng.base <= rng.limit;
   assign hit_o       = armed & ordered & (first_i <= hi_byte) & (last_i >= lo_byte);
endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard #(
   parameter int unsigned NUM_RANGES = 6,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LEN_W      = 17,
   parameter int unsigned IDX_W      = $clog2(NUM_RANGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_i,
   input  logic              cfg_we_i,
   input  logic [IDX_W-1:0]  cfg_idx_i,
   input  logic [31:0]       cfg_wdata_i,
   output logic [31:0]       cfg_rdata_o,
   input  logic              chk_req_i,
   input  logic [ADDR_W-1:0] chk_addr_i,
   input  logic [LEN_W-1:0]  chk_len_i,
   input  logic              chk_write_i,
   output logic              err_valid_o,
   output logic              err_o
);
   import frg_pkg::*;

   localparam int unsigned SPAN_W = ADDR_W + 1;

   if (NUM_RANGES < 5 || NUM_RANGES > 6) begin : g_bad_num
      $error("NUM_RANGES must be 5 or 6");
   end
   if (ADDR_W < FIELD_W + PAGE_SH || ADDR_W > 48) begin : g_bad_addr
      $error("ADDR_W out of supported range");
   end
   if (LEN_W < 1 || LEN_W > ADDR_W) begin : g_bad_len
      $error("LEN_W out of supported range");
   end
   if ((1 << IDX_W) < NUM_RANGES) begin : g_bad_idx
      $error("IDX_W too narrow for NUM_RANGES");
   end

   logic [NUM_RANGES-1:0][WORD_W-1:0] regs;
   logic [NUM_RANGES-1:0]             hits;
   logic [SPAN_W-1:0]                 first_b;
   logic [SPAN_W-1:0]                 last_b;
   logic                              any_hit;
   logic                              vld_q;
   logic                              err_q;

   frg_regfile #(
      .NUM   (NUM_RANGES),
      .IDX_W (IDX_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock_i  (lock_i),
      .we_i    (cfg_we_i),
      .idx_i   (cfg_idx_i),
      .wdata_i (cfg_wdata_i),
      .regs_o  (regs)
   );

   assign first_b = SPAN_W'(chk_addr_i);
   assign last_b  = SPAN_W'(chk_addr_i) + SPAN_W'(chk_len_i);

   for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
      frg_match #(
         .ADDR_W (ADDR_W)
      ) u_match (
         .word_i     (regs[g]),
         .first_i    (first_b),
         .last_i     (last_b),
         .is_write_i (chk_write_i),
         .hit_o      (hits[g])
      );
   end

   assign any_hit = |hits;

   always_comb begin
      cfg_rdata_o = '0;
      for (int i = 0; i < NUM_RANGES; i++) begin
         if (cfg_idx_i == IDX_W'(i)) cfg_rdata_o = regs[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         vld_q <= chk_req_i;
         err_q <= chk_req_i & any_hit;
      end
   end

   assign err_valid_o = vld_q;
   assign err_o       = err_q;
endmodule

// File: rtl/frg_chk.sv
module frg_chk #(
   parameter int unsigned NUM_RANGES = 6,
   parameter int unsigned IDX_W      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lock_i,
   input logic             cfg_we_i,
   input logic [IDX_W-1:0] cfg_idx_i,
   input logic [31:0]      cfg_rdata_o,
   input logic             chk_req_i,
   input logic             err_valid_o,
   input logic             err_o
);
   a_r9_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      chk_req_i |=> err_valid_o);
   a_r9_no_valid_without_req: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_req_i |=> !err_valid_o);
   a_r9_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !err_valid_o |-> !err_o);
   a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (!err_valid_o && !err_o));
   a_r8_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_i && cfg_we_i) |=> ($stable(cfg_idx_i) -> $stable(cfg_rdata_o)));
   a_r11_oob_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg_idx_i) >= NUM_RANGES) |-> (cfg_rdata_o == 32'h0));
endmodule

bind flash_range_guard frg_chk #(
   .NUM_RANGES (NUM_RANGES),
   .IDX_W      (IDX_W)
) u_frg_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lock_i      (lock_i),
   .cfg_we_i    (cfg_we_i),
   .cfg_idx_i   (cfg_idx_i),
   .cfg_rdata_o (cfg_rdata_o),
   .chk_req_i   (chk_req_i),
   .err_valid_o (err_valid_o),
   .err_o       (err_o)
);

// File: tb/flash_range_guard_tb_top.sv
module flash_range_guard_tb_top;
   localparam int NR = 6;
   localparam int AW = 32;
   localparam int LW = 17;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lock_i = 1'b0;
   logic          cfg_we_i = 1'b0;
   logic [IW-1:0] cfg_idx_i = '0;
   logic [31:0]   cfg_wdata_i = '0;
   logic [31:0]   cfg_rdata_o;
   logic          chk_req_i = 1'b0;
   logic [AW-1:0] chk_addr_i = '0;
   logic [LW-1:0] chk_len_i = '0;
   logic          chk_write_i = 1'b0;
   logic          err_valid_o;
   logic          err_o;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   flash_range_guard #(.NUM_RANGES(NR), .ADDR_W(AW), .LEN_W(LW), .IDX_W(IW)) dut_i (
      .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .cfg_we_i(cfg_we_i),
      .cfg_idx_i(cfg_idx_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
      .chk_req_i(chk_req_i), .chk_addr_i(chk_addr_i), .chk_len_i(chk_len_i),
      .chk_write_i(chk_write_i), .err_valid_o(err_valid_o), .err_o(err_o)
   );

   // behavioural reference
   logic [31:0] mreg [NR];
   logic        exp_v, exp_e;

   function automatic bit model_hit(longint a, longint n, bit wr);
      bit h = 0;
      for (int i = 0; i < NR; i++) begin
         longint b  = longint'(mreg[i] & 32'h3FFF);
         longint l  = longint'((mreg[i] >> 16) & 32'h3FFF);
         bit     en = wr ? mreg[i][31] : mreg[i][15];
         longint lo = b * 4096;
         longint hi = l * 4096 + 4095;
         if (en && b <= l && a <= hi && a + n >= lo) h = 1;
      end
      return h;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NR; i++) mreg[i] <= '0;
         exp_v <= 1'b0;
         exp_e <= 1'b0;
      end else begin
         exp_v <= chk_req_i;
         exp_e <= chk_req_i && model_hit(longint'(chk_addr_i), longint'(chk_len_i), chk_write_i);
         if (cfg_we_i && !lock_i && int'(cfg_idx_i) < NR) mreg[cfg_idx_i] <= cfg_wdata_i;
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model (R5 R6 R7 R9)
   always @(negedge clk) begin
      if (rst_n) begin
         check(err_valid_o === exp_v, "R9 model valid", err_valid_o, exp_v);
         check(err_o === exp_e, "R5 R6 R7 model err", err_o, exp_e);
      end
   end

   task automatic wr_cfg(input int idx, input logic [31:0] w);
      @(negedge clk);
      cfg_we_i = 1'b1; cfg_idx_i = IW'(idx); cfg_wdata_i = w;
      @(negedge clk);
      cfg_we_i = 1'b0;
   endtask

   task automatic rd_cfg(input int idx, input logic [31:0] exp, input string tag);
      cfg_idx_i = IW'(idx);
      #1;
      check(cfg_rdata_o === exp, tag, cfg_rdata_o, exp);
   endtask

   task automatic probe(input longint a, input longint n, input bit wr, input bit exp, input string tag);
      @(negedge clk);
      chk_req_i = 1'b1; chk_addr_i = AW'(a); chk_len_i = LW'(n); chk_write_i = wr;
      @(negedge clk);
      chk_req_i = 1'b0;
      #1;
      check(err_valid_o === 1'b1, {tag, " valid"}, err_valid_o, 1);
      check(err_o === exp, tag, err_o, exp);
   endtask

   function automatic logic [31:0] mk(int b, int l, bit rp, bit wp);
      return {wp, 1'b0, 14'(l), rp, 1'b0, 14'(b)};
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired actual=0x1 expected=0x0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int i = 0; i < NR; i++) rd_cfg(i, 32'h0, "R1 reset word");
      check(err_valid_o === 1'b0 && err_o === 1'b0, "R1 reset outputs", {err_valid_o, err_o}, 0);

      wr_cfg(0, mk(16'h010, 16'h01F, 1, 0));   // read-protect only
      wr_cfg(1, mk(16'h100, 16'h10F, 0, 1));   // write-protect only
      wr_cfg(2, mk(16'h200, 16'h20F, 0, 0));   // disabled
      wr_cfg(3, mk(16'h300, 16'h2FF, 1, 1));   // inverted
      wr_cfg(4, mk(16'h400, 16'h400, 1, 1));   // both, single page
      rd_cfg(0, mk(16'h010, 16'h01F, 1, 0), "R11 readback idx0");
      rd_cfg(4, mk(16'h400, 16'h400, 1, 1), "R11 readback idx4");

      probe(64'h10000, 0, 0, 1, "R5 read into read-protected");
      probe(64'h0FFFF, 0, 0, 0, "R3 byte below base");
      probe(64'h1FFFF, 0, 0, 1, "R3 inclusive limit byte");
      probe(64'h20000, 0, 0, 0, "R3 byte past limit");
      probe(64'h0F000, 64'hFFF, 0, 0, "R7 4K read ends below base");
      probe(64'h0F000, 64'h1000, 0, 1, "R7 read reaches base");
      probe(64'h10000, 0, 1, 0, "R6 write vs read-only range");
      probe(64'h100000, 64'hFFFF, 1, 1, "R6 64K erase on write-protected");
      probe(64'h0F0000, 64'hFFFF, 1, 0, "R7 64K erase ends below base");
      probe(64'h0F0000, 64'h10000, 1, 1, "R7 erase reaches base");
      probe(64'h100000, 0, 0, 0, "R5 read vs write-only range");
      probe(64'h200000, 0, 0, 0, "R4 disabled range read");
      probe(64'h200000, 64'hFFF, 1, 0, "R4 disabled range erase");
      probe(64'h300000, 0, 0, 0, "R10 inverted range read");
      probe(64'h2F0000, 64'h1FFFF, 1, 0, "R10 inverted range wide erase");
      probe(64'h400FFF, 0, 1, 1, "R2 both enables write");
      probe(64'h400000, 0, 0, 1, "R2 both enables read");
      wr_cfg(4, mk(16'h400, 16'h400, 1, 1) | 32'h4000_4000);
      probe(64'h401000, 0, 0, 0, "R2 spare bits no effect");

      // R9 idle cycle
      @(negedge clk);
      check(err_valid_o === 1'b0 && err_o === 1'b0, "R9 idle no valid", {err_valid_o, err_o}, 0);

      // R8 lock
      lock_i = 1'b1;
      wr_cfg(0, 32'h0);
      rd_cfg(0, mk(16'h010, 16'h01F, 1, 0), "R8 locked write ignored");
      probe(64'h10000, 0, 0, 1, "R8 locked range still active");
      lock_i = 1'b0;
      wr_cfg(0, 32'h0);
      rd_cfg(0, 32'h0, "R8 unlocked write taken");
      probe(64'h10000, 0, 0, 0, "R8 cleared range silent");

      // R11 out-of-range index
      wr_cfg(6, 32'hFFFF_FFFF);
      rd_cfg(6, 32'h0, "R11 idx6 reads zero");
      wr_cfg(7, 32'hFFFF_FFFF);
      rd_cfg(7, 32'h0, "R11 idx7 reads zero");
      rd_cfg(5, 32'h0, "R11 idx5 untouched");
      probe(64'h0, 64'h1FFFF, 1, 0, "R11 no stray range at zero");

      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule